// File: doc/BRIEF.md
# Embedded-Boundary Word Deserializer

This block turns a source-synchronous serial stream back into parallel words. The sender forwards a bit clock next to the data line. It marks the end of each word by leaving out one low pulse of that clock, so the clock stays high for an extended run. During that run the data line carries two framing bits. Both incoming lines are asynchronous to the local clock `clk`, which runs at least eight times faster than the bit rate. Both lines pass through synchronisers before the block uses them.

One data bit is captured on every falling edge of the forwarded clock. The block measures each high phase in local ticks and keeps the most recent normal high phase as its estimate of the half bit period H. A high run longer than 2·H is treated as a word boundary. When that run ends, the block checks the two framing bits. If they are correct, it updates the parallel outputs and produces a low pulse on the word clock. The pulse falls 6 bit times after the output update and stays low for 13 bit times. A bit time is 2·H ticks.

The input `dir_tx` is synchronous to `clk`. When it is high, the link is turned around to transmit. The word clock is then held high, the bidirectional data pins are released, and the outputs hold their last values.

Top module: `emb_word_rx`

## Requirements
- R1: After reset, `par_data_o` and `ded_data_o` are all zero, `word_clk_o` is high and `frame_err_o` is low. `par_oe_o` is high from the first clock after reset release while `dir_tx` is low.
- R2: One bit is shifted in on each synchronised falling edge of the forwarded clock. Received bit n (n = 1 is the first bit of a word) appears on `par_data_o[n-1]` for n = 1 to 20.
- R3: Received bits 21 and 22 appear on `ded_data_o[0]` and `ded_data_o[1]`. Received bits 23 and 24 reach no output.
- R4: A high run longer than 2·H ticks is a boundary. A shorter high phase ends a normal bit and its length in ticks becomes the new H. H is 4 after reset.
- R5: A correct boundary updates the outputs on the clock edge after its synchronised falling edge. `word_clk_o` falls exactly 12·H cycles after that update.
- R6: `word_clk_o` stays low for exactly 26·H cycles (13 bit times) and then stays high until the next word. The data outputs never change while it is low.
- R7: A stream with no boundary produces no word clock pulse and leaves the outputs unchanged.
- R8: One cycle after `dir_tx` is sampled high, `word_clk_o` is high and `par_oe_o` is low. Words received in that state are ignored and the outputs hold their last values. Normal operation resumes when `dir_tx` returns low.
- R9: Idle bits sent before a word do not affect it. The output word is built from the last 24 bits shifted in before the boundary.
- R10: The first framing bit is sampled H ticks into the high run and must be the inverse of received bit 24. The second is sampled at the closing falling edge and must equal bit 24. If either check fails, `frame_err_o` pulses for one cycle, the word is dropped and no word clock pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_tx | input | 1 | 1 = link turned to transmit, receive path idle |
| ser_clk_i | input | 1 | Forwarded bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| par_data_o | output | 20 | Received bits 1 to 20 |
| par_oe_o | output | 1 | Output enable for the bidirectional data pins |
| ded_data_o | output | 2 | Received bits 21 and 22 on dedicated outputs |
| word_clk_o | output | 1 | Word clock, active-low pulse per accepted word |
| frame_err_o | output | 1 | One-cycle pulse for a boundary with bad framing bits |

## Verification
The hardest case to reach from the ports is a boundary whose framing bits break the rule. A well-behaved sender never produces one. The bench transmitter can send a word in which the first framing bit equals bit 24 instead of its inverse, and it then confirms that the outputs hold and no word clock pulse appears. The learned period is driven in the same way: a word is sent at a slower half period so the word clock delay and low width have to follow the new H. The stimulus also covers idle bits before a word, a stream with no boundary at all, and words sent while the link is turned to transmit.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
    typedef enum logic [1:0] {
        WC_IDLE = 2'd0,
        WC_WAIT = 2'd1,
        WC_LOW  = 2'd2
    } wc_phase_e;
endpackage

// File: rtl/ewd_sync.sv
module ewd_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ewd_frame.sv
module ewd_frame #(
    parameter int WORD_BITS = 24,
    parameter int OUT_BITS  = 22,
    parameter int CNT_W     = 8,
    parameter int INIT_HALF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                sdat,
    output logic                word_valid,
    output logic                frame_err,
    output logic [OUT_BITS-1:0] word,
    output logic [CNT_W-1:0]    half
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic                 prev;
        logic [CNT_W-1:0]     hi_cnt;
        logic [CNT_W-1:0]     half;
        logic [WORD_BITS-1:0] shreg;
        logic                 bnd_a;
    } frame_t;

    frame_t q, d;
    logic   rise, fall, is_bnd, last_bit, frame_ok;

    always_comb begin
        d          = q;
        rise       = sclk & ~q.prev;
        fall       = ~sclk & q.prev;
        is_bnd     = fall && ({1'b0, q.hi_cnt} > {q.half, 1'b0});
        last_bit   = q.shreg[WORD_BITS-1];
        frame_ok   = (q.bnd_a == ~last_bit) && (sdat == last_bit);
        word_valid = 1'b0;
        frame_err  = 1'b0;
        d.prev     = sclk;

        if (sclk) begin
            if (rise)                  d.hi_cnt = CNT_W'(1);
            else if (q.hi_cnt != CNT_MAX) d.hi_cnt = q.hi_cnt + CNT_W'(1);
            // the point where a normal bit would have fallen
            if (!rise && q.hi_cnt == q.half) d.bnd_a = sdat;
        end

        if (fall && !is_bnd) begin
            d.shreg = {sdat, q.shreg[WORD_BITS-1:1]};
            d.half  = q.hi_cnt;
        end

        if (is_bnd) begin
            word_valid = frame_ok;
            frame_err  = ~frame_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.half   <= CNT_W'(INIT_HALF);
        end else begin
            q <= d;
        end
    end

    assign word = q.shreg[OUT_BITS-1:0];
    assign half = q.half;
endmodule

// File: rtl/ewd_wclk.sv
module ewd_wclk
    import ewd_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DELAY_BITS = 6,
    parameter int LOW_BITS   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] half,
    output logic             wclk
);
    localparam int TMR_W = CNT_W + $clog2(2 * LOW_BITS + 2 * DELAY_BITS + 1);
    localparam logic [TMR_W-1:0] DLY_MUL = TMR_W'(2 * DELAY_BITS);
    localparam logic [TMR_W-1:0] LOW_MUL = TMR_W'(2 * LOW_BITS);

    typedef struct packed {
        wc_phase_e        phase;
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] low_len;
    } wc_t;

    wc_t              q, d;
    logic [TMR_W-1:0] dly_ticks, low_ticks;

    always_comb begin
        d         = q;
        dly_ticks = DLY_MUL * TMR_W'(half);
        low_ticks = LOW_MUL * TMR_W'(half);
        if (abort) begin
            d.phase = WC_IDLE;
            d.cnt   = '0;
        end else if (start) begin
            d.phase   = WC_WAIT;
            d.cnt     = dly_ticks - TMR_W'(1);
            d.low_len = low_ticks;
        end else begin
            case (q.phase)
                WC_WAIT: begin
                    if (q.cnt == '0) begin
                        d.phase = WC_LOW;
                        d.cnt   = q.low_len - TMR_W'(1);
                    end else begin
                        d.cnt = q.cnt - TMR_W'(1);
                    end
                end
                WC_LOW: begin
                    if (q.cnt == '0) d.phase = WC_IDLE;
                    else             d.cnt   = q.cnt - TMR_W'(1);
                end
                default: d.phase = WC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: WC_IDLE, cnt: '0, low_len: '0};
        else        q <= d;
    end

    assign wclk = (q.phase != WC_LOW);
endmodule

// File: rtl/emb_word_rx.sv
module emb_word_rx #(
    parameter int WORD_BITS   = 24,
    parameter int PAR_BITS    = 20,
    parameter int DED_BITS    = 2,
    parameter int CNT_W       = 8,
    parameter int INIT_HALF   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WCLK_DELAY  = 6,
    parameter int WCLK_LOW    = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_tx,
    input  logic                ser_clk_i,
    input  logic                ser_dat_i,
    output logic [PAR_BITS-1:0] par_data_o,
    output logic                par_oe_o,
    output logic [DED_BITS-1:0] ded_data_o,
    output logic                word_clk_o,
    output logic                frame_err_o
);
    localparam int OUT_BITS = PAR_BITS + DED_BITS;

    typedef struct packed {
        logic [PAR_BITS-1:0] par;
        logic [DED_BITS-1:0] ded;
        logic                oe;
    } out_t;

    logic [1:0]          synced;
    logic                f_valid, f_err, load;
    logic [OUT_BITS-1:0] f_word;
    logic [CNT_W-1:0]    f_half;
    out_t                q, d;

    ewd_sync #(.STAGES(SYNC_STAGES), .LINES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_dat_i, ser_clk_i}),
        .sync_o  (synced)
    );

    ewd_frame #(
        .WORD_BITS (WORD_BITS),
        .OUT_BITS  (OUT_BITS),
        .CNT_W     (CNT_W),
        .INIT_HALF (INIT_HALF)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (synced[0]),
        .sdat       (synced[1]),
        .word_valid (f_valid),
        .frame_err  (f_err),
        .word       (f_word),
        .half       (f_half)
    );

    assign load = f_valid & ~dir_tx;

    ewd_wclk #(
        .CNT_W      (CNT_W),
        .DELAY_BITS (WCLK_DELAY),
        .LOW_BITS   (WCLK_LOW)
    ) i_wclk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (load),
        .abort (dir_tx),
        .half  (f_half),
        .wclk  (word_clk_o)
    );

    always_comb begin
        d    = q;
        d.oe = ~dir_tx;
        if (load) begin
            d.par = f_word[PAR_BITS-1:0];
            d.ded = f_word[PAR_BITS +: DED_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign par_data_o  = q.par;
    assign ded_data_o  = q.ded;
    assign par_oe_o    = q.oe;
    assign frame_err_o = f_err & ~dir_tx;
endmodule

// File: rtl/emb_word_rx_chk.sv
module emb_word_rx_chk #(
    parameter int PAR_BITS = 20,
    parameter int DED_BITS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dir_tx,
    input logic [PAR_BITS-1:0] par_data_o,
    input logic [DED_BITS-1:0] ded_data_o,
    input logic                par_oe_o,
    input logic                word_clk_o,
    input logic                frame_err_o
);
    assert_wclk_high_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |=> word_clk_o);

    assert_oe_off_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |=> !par_oe_o);

    assert_drop_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> $stable({par_data_o, ded_data_o}));

    assert_hold_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({par_data_o, ded_data_o}) |-> word_clk_o);

    assert_fall_after_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_clk_o) |-> $stable({par_data_o, ded_data_o}));
endmodule

bind emb_word_rx emb_word_rx_chk #(.PAR_BITS(PAR_BITS), .DED_BITS(DED_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_tx      (dir_tx),
    .par_data_o  (par_data_o),
    .ded_data_o  (ded_data_o),
    .par_oe_o    (par_oe_o),
    .word_clk_o  (word_clk_o),
    .frame_err_o (frame_err_o)
);

// File: tb/test_emb_word_rx.sv
module test_emb_word_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_tx = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic [19:0] par;
    logic [1:0]  ded;
    logic        oe, wclk, ferr;

    always #10 clk = ~clk;

    emb_word_rx i_emb_word_rx (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .par_data_o(par), .par_oe_o(oe), .ded_data_o(ded),
        .word_clk_o(wclk), .frame_err_o(ferr)
    );

    // {bad framing, idle bits, 24-bit word}
    localparam int NV = 6;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 4'd0, 24'hA5C3F1},
        {1'b0, 4'd3, 24'h3FFFFF},
        {1'b0, 4'd0, 24'h155555},
        {1'b1, 4'd0, 24'h00FF00},
        {1'b0, 4'd2, 24'hC0000E},
        {1'b0, 4'd0, 24'h2AAAAA}
    };

    int n_chk = 0, n_fail = 0;
    int half_t = 4;
    int cyc = 0, t_upd = 0, t_fall = 0, m_delay = 0, m_low = 0, n_pulse = 0, n_ferr = 0;
    logic [21:0] prev_out = '0;
    logic        prev_wclk = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if ({ded, par} !== prev_out) t_upd = cyc;
        if (prev_wclk && !wclk) begin m_delay = cyc - t_upd; t_fall = cyc; n_pulse++; end
        if (!prev_wclk && wclk) m_low = cyc - t_fall;
        if (ferr) n_ferr++;
        prev_out  = {ded, par};
        prev_wclk = wclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b; ser_clk = 1'b1;
        repeat (half_t) @(negedge clk);
        ser_clk = 1'b0;
        repeat (half_t) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w, input int idle, input bit bad);
        for (int i = 0; i < idle; i++) send_bit(1'b0);
        for (int i = 0; i < 24; i++) send_bit(w[i]);
        ser_dat = bad ? w[23] : ~w[23]; ser_clk = 1'b1;
        repeat (2 * half_t) @(negedge clk);
        ser_dat = w[23];
        repeat (half_t) @(negedge clk);
        ser_clk = 1'b0;
        repeat (half_t) @(negedge clk);
        repeat (40 * half_t) @(negedge clk);
    endtask

    task automatic expect_word(input logic [23:0] w, input int pulses0, input string req);
        chk(par === w[19:0], req, int'(par), int'(w[19:0]));
        chk(ded === w[21:20], "R3 dedicated bits", int'(ded), int'(w[21:20]));
        chk(n_pulse == pulses0 + 1, "R5 one word clock pulse", n_pulse, pulses0 + 1);
        chk(m_delay == 12 * half_t, "R5 word clock delay", m_delay, 12 * half_t);
        chk(m_low == 26 * half_t, "R6 word clock low time", m_low, 26 * half_t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [21:0] held;
        int p0, e0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(par === '0 && ded === '0, "R1 outputs zero", int'({ded, par}), 0);
        chk(wclk === 1'b1, "R1 word clock high", int'(wclk), 1);
        chk(ferr === 1'b0, "R1 no frame error", int'(ferr), 0);
        chk(oe === 1'b1, "R1 output enable", int'(oe), 1);

        // table walk: R2, R3, R4, R9, R10
        for (int v = 0; v < NV; v++) begin
            held = {ded, par};
            p0 = n_pulse; e0 = n_ferr;
            send_word(VEC[v][23:0], int'(VEC[v][27:24]), VEC[v][28]);
            if (VEC[v][28]) begin
                chk({ded, par} === held, "R10 bad word dropped", int'({ded, par}), int'(held));
                chk(n_pulse == p0, "R10 no pulse on bad word", n_pulse, p0);
                chk(n_ferr == e0 + 1, "R10 frame error pulse", n_ferr, e0 + 1);
            end else begin
                expect_word(VEC[v][23:0], p0, "R2 R9 parallel bits");
                chk(n_ferr == e0, "R10 no frame error", n_ferr, e0);
            end
        end

        // R7 no boundary
        held = {ded, par}; p0 = n_pulse;
        for (int i = 0; i < 30; i++) send_bit(i[0]);
        repeat (60 * half_t) @(negedge clk);
        chk(n_pulse == p0, "R7 no pulse without boundary", n_pulse, p0);
        chk({ded, par} === held && wclk === 1'b1, "R7 outputs held",
            int'({ded, par}), int'(held));

        // R8 transmit direction
        dir_tx = 1'b1;
        repeat (2) @(negedge clk);
        chk(oe === 1'b0, "R8 outputs released", int'(oe), 0);
        chk(wclk === 1'b1, "R8 word clock high", int'(wclk), 1);
        held = {ded, par}; p0 = n_pulse;
        send_word(24'h123456, 0, 1'b0);
        chk({ded, par} === held, "R8 word ignored", int'({ded, par}), int'(held));
        chk(n_pulse == p0, "R8 no pulse", n_pulse, p0);
        dir_tx = 1'b0;
        repeat (2) @(negedge clk);
        chk(oe === 1'b1, "R8 outputs driven again", int'(oe), 1);
        p0 = n_pulse;
        send_word(24'h0ABCDE, 0, 1'b0);
        expect_word(24'h0ABCDE, p0, "R8 resume");

        // R4 period learning with a slower sender
        half_t = 6;
        p0 = n_pulse;
        send_word(24'h3C3C3C, 1, 1'b0);
        expect_word(24'h3C3C3C, p0, "R4 learned period");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule